// File: doc/BRIEF.md
# Four-Wide In-Order Dispatch Arbiter

This block decides, every cycle, how many of the four oldest instruction-queue entries leave for the back end, and which execution unit each one goes to. There are six units: a branch unit, a memory (load/store) unit, a floating-point unit, two simple integer units and one complex integer unit. An entry may leave only if every older entry in the window leaves in the same cycle. It also needs all four of these at once: a unit that can take it, a free completion-queue entry, enough free rename registers, and a reservation-station entry, unless it takes the direct path into the unit.

The queue-facing side is a valid/ready stream, one pair for each window slot. `slot_valid[i]` is the valid and `slot_grant[i]` is the ready. A grant is formed combinationally from the current inputs, and the queue pops the granted entries at the next rising edge. The queue must keep an entry and its attributes stable until that entry is granted. `slot_valid` must not depend on `slot_grant`. Back-pressure is shown by a grant that stays low: that slot and every younger one stay in the queue.

The resource inputs (`rs_cnt`, `unit_free`, `cq_free`, `ren_free`) are plain status pins. The allocation counts are plain outputs. The routing decision is registered onto a per-unit issue bus that the execution units read one cycle later.

Top module: `disp_arbiter`

## Requirements
- R1: Only slots with `slot_valid` high can be granted. Grants always form an unbroken run starting at slot 0: if slot i is not granted, no younger slot is granted in that cycle, so at most four entries leave per cycle.
- R2: Each unit receives at most one instruction per cycle. Class codes are 0 branch, 1 memory, 2 floating point, 3 simple integer, 4 complex integer. Unit indices on `slot_unit` are 0 branch, 1 memory, 2 floating point, 3 simple integer A, 4 simple integer B, 5 complex integer. `slot_unit` reads 0 for a slot that is not granted.
- R3: An entry that does not take the direct path needs its unit's `rs_cnt` to be below the station depth (2). With a full station and no direct path, the entry blocks.
- R4: An entry takes the direct path (`iss_direct` set) exactly when `slot_rdy` is high, the unit's `unit_free` is high and its `rs_cnt` is 0. A ready entry whose unit station is non-empty, or whose unit pipeline is busy, goes to the station if there is room.
- R5: The number of granted slots never exceeds `cq_free`. Each granted slot uses one completion entry, counted in slot order.
- R6: The running sum of `slot_ndst` over granted slots, taken in slot order, never exceeds `ren_free`. An entry with `slot_ndst` = 0 needs no rename register.
- R7: Class 3 goes to simple unit A when A can accept it, and to simple unit B otherwise. Class 4 goes only to unit 5.
- R8: Class codes 5 to 7 are never granted, and they block all younger slots.
- R9: `disp_count` equals the number of granted slots. `ren_alloc` equals the sum of `slot_ndst` over the granted slots.
- R10: One clock after a grant, `iss_valid[u]` is 1 for each unit u that was chosen. `iss_direct[u]` shows the path taken, and `iss_slot[u]` gives the window slot index. Units that were not chosen read 0 on all three. Reset clears all three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slot_valid | input | 4 | Window entry present (stream valid), slot 0 oldest |
| slot_cls | input | 4x3 | Unit class of each entry |
| slot_rdy | input | 4 | All source operands of the entry available |
| slot_ndst | input | 4x2 | Number of registers the entry writes |
| rs_cnt | input | 6x2 | Occupied reservation-station entries of each unit |
| unit_free | input | 6 | Unit pipeline can accept an instruction this cycle |
| cq_free | input | 5 | Free completion-queue entries (0..16) |
| ren_free | input | 4 | Free rename registers (0..12) |
| slot_grant | output | 4 | Entry leaves this cycle (stream ready) |
| slot_unit | output | 4x3 | Target unit index of each granted entry |
| disp_count | output | 3 | Number of entries granted this cycle |
| ren_alloc | output | 4 | Rename registers taken this cycle |
| iss_valid | output | 6 | Registered: unit receives an instruction |
| iss_direct | output | 6 | Registered: instruction bypasses the station |
| iss_slot | output | 6x2 | Registered: window slot the instruction came from |

## Verification
Grants, target units, `disp_count` and `ren_alloc` are combinational, so they are due in the same cycle as the inputs. The issue bus is due one rising edge later. The bench drives each stimulus on a falling edge and holds it through the next rising edge. It samples everything 2 ns after that rising edge. At that point the combinational outputs still reflect the held stimulus, and the issue bus has just captured the same stimulus, so one scoreboard entry covers both. Directed patterns cover each blocking rule and the simple-unit fallback, and a randomized run follows them.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int NUM_UNITS = 6;
  localparam int CLS_W     = 3;
  localparam int UNIT_W    = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_BRANCH  = 3'd0,
    CLS_MEM     = 3'd1,
    CLS_FLOAT   = 3'd2,
    CLS_SIMPLE  = 3'd3,
    CLS_COMPLEX = 3'd4
  } cls_e;

  localparam int U_BR  = 0;
  localparam int U_LS  = 1;
  localparam int U_FP  = 2;
  localparam int U_SIA = 3;
  localparam int U_SIB = 4;
  localparam int U_CX  = 5;

  typedef logic [NUM_UNITS-1:0] umask_t;

  // Units a class may be steered to
  function automatic umask_t class_targets(logic [CLS_W-1:0] cls);
    umask_t m;
    m = '0;
    case (cls)
      CLS_BRANCH:  m[U_BR]  = 1'b1;
      CLS_MEM:     m[U_LS]  = 1'b1;
      CLS_FLOAT:   m[U_FP]  = 1'b1;
      CLS_SIMPLE:  begin m[U_SIA] = 1'b1; m[U_SIB] = 1'b1; end
      CLS_COMPLEX: m[U_CX]  = 1'b1;
      default:     m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/disp_unit_gate.sv
module disp_unit_gate #(
  parameter int RS_DEPTH = 2,
  localparam int RS_W = $clog2(RS_DEPTH + 1)
) (
  input  logic [RS_W-1:0] rs_cnt,
  input  logic            unit_free,
  output logic            rs_space,
  output logic            path_clear
);
  // Station can take one more entry
  assign rs_space   = (32'(rs_cnt) < RS_DEPTH);
  // Direct entry only behind an empty station and a free pipeline slot
  assign path_clear = unit_free && (rs_cnt == '0);
endmodule

// File: rtl/disp_slot_stage.sv
module disp_slot_stage
  import disp_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int CQ_W  = 5,
  parameter int REN_W = 4,
  parameter int DST_W = 2
) (
  input  logic             alive_in,
  input  umask_t           used_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [REN_W-1:0] ren_in,
  input  logic             valid,
  input  logic [CLS_W-1:0] cls,
  input  logic             rdy,
  input  logic [DST_W-1:0] ndst,
  input  umask_t           rs_space,
  input  umask_t           path_clear,
  input  logic [CQ_W-1:0]  cq_free,
  input  logic [REN_W-1:0] ren_free,
  output logic             grant,
  output logic [UNIT_W-1:0] unit,
  output logic             direct,
  output logic             alive_out,
  output umask_t           used_out,
  output logic [CNT_W-1:0] cnt_out,
  output logic [REN_W-1:0] ren_out
);
  umask_t            ok_mask;
  logic [UNIT_W-1:0] pick;
  logic              found;
  logic              cq_ok;
  logic              ren_ok;

  always_comb begin
    ok_mask = class_targets(cls) & ~used_in &
              (rs_space | (path_clear & {NUM_UNITS{rdy}}));
    found = |ok_mask;
    pick  = '0;
    // Descending scan: the lowest acceptable unit wins
    for (int u = NUM_UNITS - 1; u >= 0; u--) begin
      if (ok_mask[u]) pick = UNIT_W'(u);
    end
  end

  assign cq_ok  = (32'(cnt_in) < 32'(cq_free));
  assign ren_ok = ((32'(ren_in) + 32'(ndst)) <= 32'(ren_free));

  assign grant     = alive_in && valid && found && cq_ok && ren_ok;
  assign unit      = grant ? pick : '0;
  assign direct    = grant && rdy && path_clear[pick];
  assign alive_out = grant;

  always_comb begin
    used_out = used_in;
    if (grant) used_out[pick] = 1'b1;
  end

  assign cnt_out = cnt_in + CNT_W'(grant);
  assign ren_out = grant ? REN_W'(32'(ren_in) + 32'(ndst)) : ren_in;
endmodule

// File: rtl/disp_issue_reg.sv
module disp_issue_reg
  import disp_pkg::*;
#(
  parameter int SLOTS = 4,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [SLOTS-1:0]                   slot_grant,
  input  logic [SLOTS-1:0][UNIT_W-1:0]       slot_unit,
  input  logic [SLOTS-1:0]                   slot_direct,
  output logic [NUM_UNITS-1:0]               iss_valid,
  output logic [NUM_UNITS-1:0]               iss_direct,
  output logic [NUM_UNITS-1:0][SLOT_W-1:0]   iss_slot
);
  logic [NUM_UNITS-1:0]             nxt_valid;
  logic [NUM_UNITS-1:0]             nxt_direct;
  logic [NUM_UNITS-1:0][SLOT_W-1:0] nxt_slot;

  always_comb begin
    nxt_valid  = '0;
    nxt_direct = '0;
    nxt_slot   = '0;
    for (int s = 0; s < SLOTS; s++) begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (slot_grant[s] && (slot_unit[s] == UNIT_W'(u))) begin
          nxt_valid[u]  = 1'b1;
          nxt_direct[u] = slot_direct[s];
          nxt_slot[u]   = SLOT_W'(s);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_valid  <= '0;
      iss_direct <= '0;
      iss_slot   <= '0;
    end else begin
      iss_valid  <= nxt_valid;
      iss_direct <= nxt_direct;
      iss_slot   <= nxt_slot;
    end
  end
endmodule

// File: rtl/disp_arbiter.sv
module disp_arbiter
  import disp_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int RS_DEPTH = 2,
  parameter int CQ_DEPTH = 16,
  parameter int REN_REGS = 12,
  parameter int DST_W    = 2,
  localparam int RS_W   = $clog2(RS_DEPTH + 1),
  localparam int CQ_W   = $clog2(CQ_DEPTH + 1),
  localparam int REN_W  = $clog2(REN_REGS + 1),
  localparam int CNT_W  = $clog2(SLOTS + 1),
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [SLOTS-1:0]                 slot_valid,
  input  logic [SLOTS-1:0][CLS_W-1:0]      slot_cls,
  input  logic [SLOTS-1:0]                 slot_rdy,
  input  logic [SLOTS-1:0][DST_W-1:0]      slot_ndst,
  input  logic [NUM_UNITS-1:0][RS_W-1:0]   rs_cnt,
  input  logic [NUM_UNITS-1:0]             unit_free,
  input  logic [CQ_W-1:0]                  cq_free,
  input  logic [REN_W-1:0]                 ren_free,
  output logic [SLOTS-1:0]                 slot_grant,
  output logic [SLOTS-1:0][UNIT_W-1:0]     slot_unit,
  output logic [CNT_W-1:0]                 disp_count,
  output logic [REN_W-1:0]                 ren_alloc,
  output logic [NUM_UNITS-1:0]             iss_valid,
  output logic [NUM_UNITS-1:0]             iss_direct,
  output logic [NUM_UNITS-1:0][SLOT_W-1:0] iss_slot
);
  umask_t rs_space;
  umask_t path_clear;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    disp_unit_gate #(.RS_DEPTH(RS_DEPTH)) u_gate (
      .rs_cnt    (rs_cnt[u]),
      .unit_free (unit_free[u]),
      .rs_space  (rs_space[u]),
      .path_clear(path_clear[u])
    );
  end

  // Resource chain threaded oldest to youngest
  logic   [SLOTS:0]            alive;
  umask_t [SLOTS:0]            used;
  logic   [SLOTS:0][CNT_W-1:0] cnt;
  logic   [SLOTS:0][REN_W-1:0] ren;
  logic   [SLOTS-1:0]          slot_direct;

  assign alive[0] = 1'b1;
  assign used[0]  = '0;
  assign cnt[0]   = '0;
  assign ren[0]   = '0;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    disp_slot_stage #(
      .CNT_W(CNT_W), .CQ_W(CQ_W), .REN_W(REN_W), .DST_W(DST_W)
    ) u_stage (
      .alive_in  (alive[s]),
      .used_in   (used[s]),
      .cnt_in    (cnt[s]),
      .ren_in    (ren[s]),
      .valid     (slot_valid[s]),
      .cls       (slot_cls[s]),
      .rdy       (slot_rdy[s]),
      .ndst      (slot_ndst[s]),
      .rs_space  (rs_space),
      .path_clear(path_clear),
      .cq_free   (cq_free),
      .ren_free  (ren_free),
      .grant     (slot_grant[s]),
      .unit      (slot_unit[s]),
      .direct    (slot_direct[s]),
      .alive_out (alive[s+1]),
      .used_out  (used[s+1]),
      .cnt_out   (cnt[s+1]),
      .ren_out   (ren[s+1])
    );
  end

  assign disp_count = cnt[SLOTS];
  assign ren_alloc  = ren[SLOTS];

  disp_issue_reg #(.SLOTS(SLOTS)) u_issue (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_grant (slot_grant),
    .slot_unit  (slot_unit),
    .slot_direct(slot_direct),
    .iss_valid  (iss_valid),
    .iss_direct (iss_direct),
    .iss_slot   (iss_slot)
  );
endmodule

// File: rtl/disp_arbiter_chk.sv
module disp_arbiter_chk
  import disp_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int RS_DEPTH = 2,
  parameter int CQ_DEPTH = 16,
  parameter int REN_REGS = 12,
  parameter int DST_W    = 2,
  localparam int RS_W  = $clog2(RS_DEPTH + 1),
  localparam int CQ_W  = $clog2(CQ_DEPTH + 1),
  localparam int REN_W = $clog2(REN_REGS + 1),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [SLOTS-1:0]               slot_valid,
  input logic [SLOTS-1:0][CLS_W-1:0]    slot_cls,
  input logic [SLOTS-1:0][DST_W-1:0]    slot_ndst,
  input logic [NUM_UNITS-1:0][RS_W-1:0] rs_cnt,
  input logic [NUM_UNITS-1:0]           unit_free,
  input logic [CQ_W-1:0]                cq_free,
  input logic [REN_W-1:0]               ren_free,
  input logic [SLOTS-1:0]               slot_grant,
  input logic [SLOTS-1:0][UNIT_W-1:0]   slot_unit,
  input logic [CNT_W-1:0]               disp_count,
  input logic [REN_W-1:0]               ren_alloc,
  input logic [NUM_UNITS-1:0]           iss_valid,
  input logic [NUM_UNITS-1:0]           iss_direct
);
  logic [NUM_UNITS-1:0][SLOTS-1:0] hits;
  logic [NUM_UNITS-1:0]            chosen;
  int                              ndst_sum;

  always_comb begin
    hits     = '0;
    ndst_sum = 0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_grant[s]) ndst_sum += 32'(slot_ndst[s]);
      for (int u = 0; u < NUM_UNITS; u++)
        hits[u][s] = slot_grant[s] && (slot_unit[s] == UNIT_W'(u));
    end
    for (int u = 0; u < NUM_UNITS; u++) chosen[u] = |hits[u];
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_s
    assert_valid_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
      slot_grant[s] |-> slot_valid[s]);
    assert_known_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_grant[s] |-> (slot_cls[s] <= CLS_COMPLEX));
    assert_complex_unit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_grant[s] && slot_cls[s] == CLS_COMPLEX) |-> (slot_unit[s] == UNIT_W'(U_CX)));
    if (s > 0) begin : g_ord
      assert_in_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_grant[s] |-> slot_grant[s-1]);
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
    assert_one_per_unit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hits[u]));
    assert_rs_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[u] && !iss_direct[u]) |-> $past(32'(rs_cnt[u]) < RS_DEPTH));
    assert_direct_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
      iss_direct[u] |-> $past(rs_cnt[u] == '0 && unit_free[u]));
  end

  assert_cq_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(disp_count) <= 32'(cq_free));
  assert_rename_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ren_alloc) <= 32'(ren_free));
  assert_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(disp_count) == $countones(slot_grant)) && (32'(ren_alloc) == ndst_sum));
  assert_issue_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (iss_valid == $past(chosen)));
endmodule

bind disp_arbiter disp_arbiter_chk #(
  .SLOTS(SLOTS), .RS_DEPTH(RS_DEPTH), .CQ_DEPTH(CQ_DEPTH),
  .REN_REGS(REN_REGS), .DST_W(DST_W)
) u_chk (.*);

// File: tb/test_disp_arbiter.sv
`timescale 1ns/1ps
module test_disp_arbiter;
  import disp_pkg::*;

  localparam int SLOTS = 4;
  localparam int NU    = NUM_UNITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [SLOTS-1:0]            slot_valid;
  logic [SLOTS-1:0][2:0]       slot_cls;
  logic [SLOTS-1:0]            slot_rdy;
  logic [SLOTS-1:0][1:0]       slot_ndst;
  logic [NU-1:0][1:0]          rs_cnt;
  logic [NU-1:0]               unit_free;
  logic [4:0]                  cq_free;
  logic [3:0]                  ren_free;
  logic [SLOTS-1:0]            slot_grant;
  logic [SLOTS-1:0][2:0]       slot_unit;
  logic [2:0]                  disp_count;
  logic [3:0]                  ren_alloc;
  logic [NU-1:0]               iss_valid;
  logic [NU-1:0]               iss_direct;
  logic [NU-1:0][1:0]          iss_slot;

  disp_arbiter i_disp_arbiter (.*);

  // Staging for the next stimulus
  logic [SLOTS-1:0]      s_valid;
  logic [SLOTS-1:0][2:0] s_cls;
  logic [SLOTS-1:0]      s_rdy;
  logic [SLOTS-1:0][1:0] s_ndst;
  logic [NU-1:0][1:0]    s_rs;
  logic [NU-1:0]         s_free;
  int                    s_cq;
  int                    s_ren;

  typedef struct {
    logic [SLOTS-1:0]      grant;
    logic [SLOTS-1:0][2:0] unit;
    int                    cnt;
    int                    ren;
    logic [NU-1:0]         iv;
    logic [NU-1:0]         idir;
    logic [NU-1:0][1:0]    islot;
    string                 req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_stage();
    s_valid = '0; s_cls = '0; s_rdy = '0; s_ndst = '0;
    s_rs = '0; s_free = '1; s_cq = 16; s_ren = 12;
  endtask

  task automatic set_slot(input int i, input int cls, input bit rdy, input int nd);
    s_valid[i] = 1'b1;
    s_cls[i]   = 3'(cls);
    s_rdy[i]   = rdy;
    s_ndst[i]  = 2'(nd);
  endtask

  // Reference built from the requirement list
  task automatic model(output exp_t e);
    logic [NU-1:0] used;
    bit alive;
    int cnt, ren;
    used = '0; alive = 1; cnt = 0; ren = 0;
    e.grant = '0; e.unit = '0; e.iv = '0; e.idir = '0; e.islot = '0;
    for (int i = 0; i < SLOTS; i++) begin
      int pick;
      bit dir;
      pick = -1; dir = 0;
      for (int u = 0; u < NU; u++) begin
        bit tgt, room, direct_ok;
        case (int'(s_cls[i]))
          0: tgt = (u == 0);
          1: tgt = (u == 1);
          2: tgt = (u == 2);
          3: tgt = (u == 3) || (u == 4);
          4: tgt = (u == 5);
          default: tgt = 0;
        endcase
        room      = int'(s_rs[u]) < 2;
        direct_ok = s_rdy[i] && s_free[u] && (s_rs[u] == 0);
        if (pick < 0 && tgt && !used[u] && (room || direct_ok)) begin
          pick = u; dir = direct_ok;
        end
      end
      if (alive && s_valid[i] && pick >= 0 && cnt < s_cq &&
          ren + int'(s_ndst[i]) <= s_ren) begin
        e.grant[i] = 1'b1;
        e.unit[i]  = 3'(pick);
        used[pick] = 1'b1;
        cnt++;
        ren += int'(s_ndst[i]);
        e.iv[pick]    = 1'b1;
        e.idir[pick]  = dir;
        e.islot[pick] = 2'(i);
      end else begin
        alive = 0;
      end
    end
    e.cnt = cnt;
    e.ren = ren;
  endtask

  // Driver: apply staged stimulus at a falling edge and queue the expectation
  task automatic drive(input string req);
    exp_t e;
    @(negedge clk);
    slot_valid = s_valid; slot_cls = s_cls; slot_rdy = s_rdy; slot_ndst = s_ndst;
    rs_cnt = s_rs; unit_free = s_free; cq_free = 5'(s_cq); ren_free = 4'(s_ren);
    model(e);
    e.req = req;
    q.push_back(e);
  endtask

  // Monitor: 2 ns after a rising edge both the held combinational result
  // and the freshly registered issue bus belong to the same stimulus
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #2;
      if (rst_n && q.size() > 0) begin
        e = q.pop_front();
        check(slot_grant == e.grant, e.req, "grant (R1)", 32'(slot_grant), 32'(e.grant));
        check(slot_unit == e.unit, e.req, "unit (R2/R7)", 32'(slot_unit), 32'(e.unit));
        check(int'(disp_count) == e.cnt && int'(ren_alloc) == e.ren, e.req,
              "count/rename (R9)", {disp_count, 12'd0, ren_alloc},
              {3'(e.cnt), 12'd0, 4'(e.ren)});
        check(iss_valid == e.iv && iss_direct == e.idir, e.req, "issue bus (R10)",
              {iss_valid, 8'd0, iss_direct}, {e.iv, 8'd0, e.idir});
        check(iss_slot == e.islot, e.req, "issue slot (R10)", 32'(iss_slot), 32'(e.islot));
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_stage();
    slot_valid = '0; slot_cls = '0; slot_rdy = '0; slot_ndst = '0;
    rs_cnt = '0; unit_free = '1; cq_free = 5'd16; ren_free = 4'd12;
    repeat (3) @(posedge clk);
    #2;
    // R10 reset state
    check(iss_valid == '0 && iss_direct == '0 && iss_slot == '0, "R10", "reset issue bus",
          32'(iss_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R4: one of each unit kind, all ready and empty -> four direct grants
    clear_stage();
    set_slot(0, 0, 1, 0); set_slot(1, 1, 1, 1); set_slot(2, 2, 1, 1); set_slot(3, 3, 1, 1);
    drive("R1");
    // R2 R7: three simple ops; A then B, third blocks, younger memory op blocked
    clear_stage();
    set_slot(0, 3, 1, 1); set_slot(1, 3, 1, 1); set_slot(2, 3, 1, 1); set_slot(3, 1, 1, 0);
    drive("R7");
    // R7: complex integer goes to unit 5 only
    clear_stage();
    set_slot(0, 4, 0, 1); set_slot(1, 4, 1, 1);
    drive("R7");
    // R3: station full, not ready -> nothing leaves
    clear_stage();
    set_slot(0, 2, 0, 1); set_slot(1, 0, 1, 0);
    s_rs[U_FP] = 2'd2;
    drive("R3");
    // R3: station full but direct path open is impossible (station not empty) even when ready
    clear_stage();
    set_slot(0, 2, 1, 1);
    s_rs[U_FP] = 2'd2;
    drive("R3");
    // R4: ready, station holds one older entry -> station path
    clear_stage();
    set_slot(0, 1, 1, 1);
    s_rs[U_LS] = 2'd1;
    drive("R4");
    // R4: ready, empty station, busy pipeline -> station path
    clear_stage();
    set_slot(0, 1, 1, 1);
    s_free[U_LS] = 1'b0;
    drive("R4");
    // R5: two completion entries left
    clear_stage();
    set_slot(0, 0, 1, 0); set_slot(1, 1, 1, 0); set_slot(2, 2, 1, 0); set_slot(3, 4, 1, 0);
    s_cq = 2;
    drive("R5");
    // R5: no completion entries
    s_cq = 0;
    drive("R5");
    // R6: rename cumulative: 2 then 2 with three free -> only first
    clear_stage();
    set_slot(0, 3, 1, 2); set_slot(1, 4, 1, 2); set_slot(2, 0, 1, 0);
    s_ren = 3;
    drive("R6");
    // R6: no rename registers, zero-destination entries still leave
    clear_stage();
    set_slot(0, 0, 1, 0); set_slot(1, 1, 0, 0); set_slot(2, 2, 1, 1);
    s_ren = 0;
    drive("R6");
    // R8: unknown class blocks younger entries
    clear_stage();
    set_slot(0, 1, 1, 1); set_slot(1, 6, 1, 0); set_slot(2, 0, 1, 0);
    drive("R8");
    // R1: gap in valid stops the run
    clear_stage();
    set_slot(0, 2, 1, 1); set_slot(2, 0, 1, 0);
    drive("R1");
    // R7: simple unit A full and busy -> unit B
    clear_stage();
    set_slot(0, 3, 1, 1);
    s_rs[U_SIA] = 2'd2; s_free[U_SIA] = 1'b0;
    drive("R7");
    // R2: two branches, second must wait
    clear_stage();
    set_slot(0, 0, 1, 0); set_slot(1, 0, 1, 0);
    drive("R2");
    // R9 R10: randomized mix
    for (int n = 0; n < 400; n++) begin
      clear_stage();
      for (int i = 0; i < SLOTS; i++) begin
        s_valid[i] = ($urandom_range(0, 7) != 0);
        s_cls[i]   = 3'($urandom_range(0, 6) == 6 ? 5 + $urandom_range(0, 2)
                                                : $urandom_range(0, 4));
        s_rdy[i]   = 1'($urandom_range(0, 1));
        s_ndst[i]  = 2'($urandom_range(0, 2));
      end
      for (int u = 0; u < NU; u++) begin
        s_rs[u]   = 2'($urandom_range(0, 2));
        s_free[u] = 1'($urandom_range(0, 1));
      end
      s_cq  = $urandom_range(0, 16);
      s_ren = $urandom_range(0, 12);
      drive("R9");
    end
    clear_stage();
    drive("R10");
    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule